// File: doc/BRIEF.md
# Register Stack Save/Restore Sequencer

This block moves a chosen group of processor registers to or from a stack in byte-wide memory. The stack grows downward. An 8-bit select mask names the registers, and a pointer-choice input picks one of two 16-bit stack pointers (the system pointer S or the user pointer U). The caller presents the current register values and pulses `start`. The sequencer then makes one single-byte memory access per clock. When the transfer ends it writes the moved pointer back through its register-file write port, pulses `done`, and reports how many bytes it transferred.

A restore sends every value it loads to the same write port, tagged with a register identifier. A save reads only the values captured when the operation was accepted. For interrupt entry the caller asks for one of two fixed saves:
- A full save overrides the mask and the direction, stores all eight slots, and sets the entire-state flag (bit 7) in the stored condition byte.
- A fast save stores only PC and the condition byte, with that flag cleared.

Top module: `stkseq_top`

## Requirements
- R1: Mask bits select slots as follows: bit 0 is CC, bit 1 is A, bit 2 is B, bit 3 is DP, bit 4 is X, bit 5 is Y, bit 6 is the other pointer and bit 7 is PC. A save stores slots from bit 7 down to bit 0, decrementing the pointer before each byte. A 16-bit slot writes its low byte first at pointer-1 and its high byte next at pointer-2, so the high byte ends at the lower address.
- R2: A restore loads slots from bit 0 up to bit 7, exactly the reverse of a save. It reads at the pointer and increments after each byte, high byte first for 16-bit slots. Each slot is delivered once on the write port with `rfSel` equal to 0 to 5 for CC, A, B, DP, X and Y, 6 for U, 7 for PC and 8 for S. 8-bit values are zero-extended.
- R3: In the cycle `done` is high, the write port carries the chosen pointer (`rfSel` 8 when `useAltSp`=0, 6 when `useAltSp`=1). Its value is the start value minus the byte count after a save, or plus the byte count after a restore.
- R4: Mask bit 6 stands for U when S is the chosen pointer and for S when U is chosen. A save stores that pointer's value. A restore delivers it under that pointer's identifier.
- R5: `cycleCount` at `done` equals 2 per selected 16-bit slot plus 1 per selected 8-bit slot. Exactly that many memory accesses occur, one per consecutive cycle starting the cycle after `start` is sampled, and `done` follows in the next cycle.
- R6: `intReq`=1 performs a full save no matter what `selMask` and `dirPull` are. All eight slots are stored, with bit 7 of the stored CC forced to 1.
- R7: `intReq`=2 performs a fast save of PC and CC only (3 bytes), with bit 7 of the stored CC forced to 0.
- R8: A zero effective mask raises `done` in the cycle after `start` with no memory access, a count of 0 and the pointer unchanged.
- R9: Pointer arithmetic wraps modulo 2^16.
- R10: Out of reset, `memValid`, `rfWe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| dirPull | input | 1 | 0 = save, 1 = restore |
| useAltSp | input | 1 | 0 = use S, 1 = use U |
| intReq | input | 2 | 0 = mask-driven, 1 = full interrupt save, 2 = fast interrupt save |
| selMask | input | 8 | Register select mask |
| ccIn | input | 8 | Condition byte |
| aIn | input | 8 | Accumulator A |
| bIn | input | 8 | Accumulator B |
| dpIn | input | 8 | Direct page |
| xIn | input | 16 | Index X |
| yIn | input | 16 | Index Y |
| sIn | input | 16 | System stack pointer |
| uIn | input | 16 | User stack pointer |
| pcIn | input | 16 | Program counter |
| memValid | output | 1 | Memory access this cycle |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Byte address |
| memWData | output | 8 | Write byte |
| memRData | input | 8 | Read byte, valid in the same cycle as the address |
| rfWe | output | 1 | Register write strobe |
| rfSel | output | 4 | Register identifier |
| rfData | output | 16 | Register write value |
| done | output | 1 | One-cycle completion pulse |
| cycleCount | output | 4 | Bytes transferred, valid with done |

## Verification
The bench sweeps all 256 masks with each pointer choice. Every save is followed by a restore from the resulting pointer.

An ordering mistake leaves values at the wrong addresses, or makes the write-port order differ from ascending bit order. A wrong byte order swaps the halves of every restored word. A missing swap of the bit-6 pointer restores the chosen pointer under the wrong identifier.

The empty mask is checked for a one-cycle completion with no memory access. A full save started at pointer 0x0002 checks the wrap to 0xFFF6, and the two interrupt saves check that the entry flag is forced while the caller's mask and direction are ignored.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;
  localparam int PTR_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int SLOTS     = 8;
  localparam int MAX_BYTES = 12;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  localparam logic [1:0] INT_NONE = 2'd0;
  localparam logic [1:0] INT_FULL = 2'd1;
  localparam logic [1:0] INT_FAST = 2'd2;

  localparam logic [SLOTS-1:0] FULL_MASK = 8'hFF;
  localparam logic [SLOTS-1:0] FAST_MASK = 8'h81;

  typedef enum logic [3:0] {
    RID_CC = 4'd0, RID_A = 4'd1, RID_B = 4'd2, RID_DP = 4'd3,
    RID_X  = 4'd4, RID_Y = 4'd5, RID_U = 4'd6, RID_PC = 4'd7,
    RID_S  = 4'd8
  } regId_t;

  typedef struct packed {
    logic       capture;
    logic       memGo;
    logic       pull;
    logic [2:0] slot;
    logic       second;
    logic       finish;
  } strobes_t;
endpackage

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
  import stkseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 dirPull,
  input  logic [1:0]           intReq,
  input  logic [SLOTS-1:0]     selMask,
  output strobes_t             stb,
  output logic [CNT_W-1:0]     byteCount
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;

  state_t            state;
  logic [SLOTS-1:0]  pend;
  logic              second;
  logic              pull;
  logic [2:0]        curSlot;
  logic              lastByte;
  logic [SLOTS-1:0]  pendNext;
  logic [SLOTS-1:0]  effMask;
  logic              effPull;

  always_comb begin
    unique case (intReq)
      INT_FULL: begin effMask = FULL_MASK; effPull = 1'b0; end
      INT_FAST: begin effMask = FAST_MASK; effPull = 1'b0; end
      default:  begin effMask = selMask;   effPull = dirPull; end
    endcase
  end

  // Save walks from the top bit downward, restore from the bottom bit upward.
  always_comb begin
    curSlot = '0;
    if (pull) begin
      for (int i = SLOTS - 1; i >= 0; i--)
        if (pend[i]) curSlot = 3'(i);
    end else begin
      for (int i = 0; i < SLOTS; i++)
        if (pend[i]) curSlot = 3'(i);
    end
  end

  assign lastByte = !curSlot[2] || second;
  assign pendNext = pend & ~(8'(1) << curSlot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pend      <= '0;
      second    <= 1'b0;
      pull      <= 1'b0;
      byteCount <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          pend      <= effMask;
          pull      <= effPull;
          second    <= 1'b0;
          byteCount <= '0;
          state     <= (effMask == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          byteCount <= byteCount + 1'b1;
          if (lastByte) begin
            second <= 1'b0;
            pend   <= pendNext;
            if (pendNext == '0) state <= ST_FIN;
          end else begin
            second <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.capture = (state == ST_IDLE) && start;
    stb.memGo   = (state == ST_RUN);
    stb.pull    = pull;
    stb.slot    = curSlot;
    stb.second  = second;
    stb.finish  = (state == ST_FIN);
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !stb.finish);
  assert_fin_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> pend == '0);
  assert_run_has_work_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.memGo |-> pend != '0);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> byteCount <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/stkseq_dpath.sv
module stkseq_dpath
  import stkseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              useAltSp,
  input  logic [1:0]        intReq,
  input  logic [BYTE_W-1:0] ccIn,
  input  logic [BYTE_W-1:0] aIn,
  input  logic [BYTE_W-1:0] bIn,
  input  logic [BYTE_W-1:0] dpIn,
  input  logic [PTR_W-1:0]  xIn,
  input  logic [PTR_W-1:0]  yIn,
  input  logic [PTR_W-1:0]  sIn,
  input  logic [PTR_W-1:0]  uIn,
  input  logic [PTR_W-1:0]  pcIn,
  output logic              memValid,
  output logic              memWrite,
  output logic [PTR_W-1:0]  memAddr,
  output logic [BYTE_W-1:0] memWData,
  input  logic [BYTE_W-1:0] memRData,
  output logic              rfWe,
  output logic [3:0]        rfSel,
  output logic [PTR_W-1:0]  rfData
);
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  word [SLOTS];
  logic              altSel;
  logic [BYTE_W-1:0] holdHi;
  logic [PTR_W-1:0]  curVal;
  logic              is16;
  logic [3:0]        slotId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      altSel <= 1'b0;
      holdHi <= '0;
      for (int i = 0; i < SLOTS; i++) word[i] <= '0;
    end else if (stb.capture) begin
      ptr      <= useAltSp ? uIn : sIn;
      altSel   <= useAltSp;
      word[0]  <= {8'h00, (intReq == INT_FULL) ? (ccIn | 8'h80) :
                          (intReq == INT_FAST) ? (ccIn & 8'h7F) : ccIn};
      word[1]  <= {8'h00, aIn};
      word[2]  <= {8'h00, bIn};
      word[3]  <= {8'h00, dpIn};
      word[4]  <= xIn;
      word[5]  <= yIn;
      word[6]  <= useAltSp ? sIn : uIn;
      word[7]  <= pcIn;
    end else if (stb.memGo) begin
      ptr <= stb.pull ? ptr + 1'b1 : ptr - 1'b1;
      if (stb.pull && is16 && !stb.second) holdHi <= memRData;
    end
  end

  assign is16   = stb.slot[2];
  assign curVal = word[stb.slot];
  assign slotId = (stb.slot == 3'd6) ? (altSel ? 4'(RID_S) : 4'(RID_U)) : {1'b0, stb.slot};

  always_comb begin
    memValid = stb.memGo;
    memWrite = stb.memGo && !stb.pull;
    memAddr  = stb.pull ? ptr : ptr - 1'b1;
    memWData = stb.second ? curVal[15:8] : curVal[7:0];
    rfWe     = 1'b0;
    rfSel    = '0;
    rfData   = '0;
    if (stb.finish) begin
      rfWe   = 1'b1;
      rfSel  = altSel ? 4'(RID_U) : 4'(RID_S);
      rfData = ptr;
    end else if (stb.memGo && stb.pull && (!is16 || stb.second)) begin
      rfWe   = 1'b1;
      rfSel  = slotId;
      rfData = is16 ? {holdHi, memRData} : {8'h00, memRData};
    end
  end

  assert_push_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memGo && !stb.pull) |=> ptr == $past(ptr) - 16'd1);
  assert_pull_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memGo && stb.pull) |=> ptr == $past(ptr) + 16'd1);
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.memGo && !stb.capture) |=> $stable(ptr));
  assert_rf_only_pull_R2: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (stb.finish || stb.pull));
  assert_no_mem_at_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> !memValid);
endmodule

// File: rtl/stkseq_top.sv
module stkseq_top
  import stkseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         dirPull,
  input  logic         useAltSp,
  input  logic [1:0]   intReq,
  input  logic [7:0]   selMask,
  input  logic [7:0]   ccIn,
  input  logic [7:0]   aIn,
  input  logic [7:0]   bIn,
  input  logic [7:0]   dpIn,
  input  logic [15:0]  xIn,
  input  logic [15:0]  yIn,
  input  logic [15:0]  sIn,
  input  logic [15:0]  uIn,
  input  logic [15:0]  pcIn,
  output logic         memValid,
  output logic         memWrite,
  output logic [15:0]  memAddr,
  output logic [7:0]   memWData,
  input  logic [7:0]   memRData,
  output logic         rfWe,
  output logic [3:0]   rfSel,
  output logic [15:0]  rfData,
  output logic         done,
  output logic [3:0]   cycleCount
);
  strobes_t stb;
  logic [CNT_W-1:0] cnt;

  stkseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dirPull(dirPull),
    .intReq(intReq), .selMask(selMask), .stb(stb), .byteCount(cnt)
  );

  stkseq_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .useAltSp(useAltSp), .intReq(intReq),
    .ccIn(ccIn), .aIn(aIn), .bIn(bIn), .dpIn(dpIn), .xIn(xIn), .yIn(yIn),
    .sIn(sIn), .uIn(uIn), .pcIn(pcIn),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData),
    .rfWe(rfWe), .rfSel(rfSel), .rfData(rfData)
  );

  assign done       = stb.finish;
  assign cycleCount = 4'(cnt);
endmodule

// File: tb/test_stkseq_top.sv
module test_stkseq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, dirPull = 1'b0, useAltSp = 1'b0;
  logic [1:0] intReq = 2'd0;
  logic [7:0] selMask = '0, ccIn = '0, aIn = '0, bIn = '0, dpIn = '0;
  logic [15:0] xIn = '0, yIn = '0, sIn = '0, uIn = '0, pcIn = '0;
  logic memValid, memWrite, rfWe, done;
  logic [15:0] memAddr, rfData;
  logic [7:0] memWData, memRData;
  logic [3:0] rfSel, cycleCount;

  logic [7:0] memArr [256];
  assign memRData = memArr[memAddr[7:0]];

  always #2.5 clk = ~clk;

  stkseq_top i_stkseq_top (.*);

  int nChk = 0, nBad = 0;
  logic [3:0]  seqId [12];
  logic [15:0] seqVal [12];
  int seqLen, memAcc, doneCyc;
  logic gotDone;
  logic [15:0] finalPtr;
  logic [3:0]  finalId;
  logic [3:0]  cntOut;
  logic [15:0] otherV;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setRegs(input logic [7:0] k);
    ccIn = {k[3:0], k[7:4]} ^ 8'h5A;
    aIn  = k + 8'h11;
    bIn  = k ^ 8'hC3;
    dpIn = ~k;
    xIn  = {k, 8'h3C} + 16'h0101;
    yIn  = {8'h9E, k};
    pcIn = {~k, k} ^ 16'h1234;
    otherV = 16'h4000 + {8'h00, k};
  endtask

  function automatic logic [15:0] slotVal(input int s, input logic [7:0] ccUse);
    case (s)
      0: return {8'h00, ccUse};
      1: return {8'h00, aIn};
      2: return {8'h00, bIn};
      3: return {8'h00, dpIn};
      4: return xIn;
      5: return yIn;
      6: return otherV;
      default: return pcIn;
    endcase
  endfunction

  function automatic int byteSum(input logic [7:0] mk);
    return 2 * $countones(mk[7:4]) + $countones(mk[3:0]);
  endfunction

  task automatic runOp(input logic pl, input logic al, input logic [1:0] iq,
                       input logic [7:0] mk, input logic [15:0] spv);
    int cyc;
    dirPull = pl; useAltSp = al; intReq = iq; selMask = mk;
    if (al) begin uIn = spv; sIn = otherV; end
    else    begin sIn = spv; uIn = otherV; end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seqLen = 0; memAcc = 0; gotDone = 1'b0; cyc = 0;
    finalPtr = '0; finalId = '0; cntOut = '0; doneCyc = -1;
    while (!gotDone && cyc < 40) begin
      if (memValid) begin
        memAcc++;
        if (memWrite) memArr[memAddr[7:0]] = memWData;
      end
      if (done) begin
        gotDone = 1'b1; doneCyc = cyc; cntOut = cycleCount;
        if (rfWe) begin finalPtr = rfData; finalId = rfSel; end
      end else begin
        if (rfWe && seqLen < 12) begin
          seqId[seqLen] = rfSel; seqVal[seqLen] = rfData; seqLen++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    check(gotDone, "R5 completion", {31'd0, gotDone}, 32'd1);
    @(negedge clk);
  endtask

  task automatic checkImage(input logic [7:0] mk, input logic [15:0] spv,
                            input logic [7:0] ccUse, input string tag);
    logic [15:0] p = spv;
    logic [15:0] v;
    for (int s = 7; s >= 0; s--) begin
      if (mk[s]) begin
        v = slotVal(s, ccUse);
        if (s >= 4) begin
          p = p - 16'd1;
          check(memArr[p[7:0]] == v[7:0], tag, {24'd0, memArr[p[7:0]]}, {24'd0, v[7:0]});
          p = p - 16'd1;
          check(memArr[p[7:0]] == v[15:8], tag, {24'd0, memArr[p[7:0]]}, {24'd0, v[15:8]});
        end else begin
          p = p - 16'd1;
          check(memArr[p[7:0]] == v[7:0], tag, {24'd0, memArr[p[7:0]]}, {24'd0, v[7:0]});
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [15:0] base;
    logic [15:0] pushed;
    int k;
    logic [3:0] expId;
    for (int i = 0; i < 256; i++) memArr[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!memValid && !rfWe && !done, "R10 reset",
          {29'd0, memValid, rfWe, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memValid && !rfWe && !done, "R10 after release",
          {29'd0, memValid, rfWe, done}, 32'd0);

    for (int alt = 0; alt < 2; alt++) begin
      for (int m = 0; m < 256; m++) begin
        logic [7:0] mk = 8'(m);
        setRegs(mk);
        base = 16'h0180;
        runOp(1'b0, alt[0], 2'd0, mk, base);
        // R5: count and timing
        check(cntOut == 4'(byteSum(mk)), "R5 count", {28'd0, cntOut}, byteSum(mk));
        check(memAcc == byteSum(mk), "R5 accesses", memAcc, byteSum(mk));
        check(doneCyc == byteSum(mk), "R5 done timing", doneCyc, byteSum(mk));
        // R3: pointer result and identifier
        check(finalPtr == base - 16'(byteSum(mk)), "R3 push pointer", finalPtr, base - 16'(byteSum(mk)));
        check(finalId == (alt[0] ? 4'd6 : 4'd8), "R3 pointer id", finalId, alt[0] ? 6 : 8);
        if (mk == 8'h00)
          check(finalPtr == base && memAcc == 0 && doneCyc == 0, "R8 empty mask",
                finalPtr, base);
        // R1 and R4: memory image
        checkImage(mk, base, ccIn, "R1 push image");
        pushed = finalPtr;
        runOp(1'b1, alt[0], 2'd0, mk, pushed);
        check(finalPtr == base, "R3 pull pointer", finalPtr, base);
        check(seqLen == $countones(mk), "R2 write count", seqLen, $countones(mk));
        k = 0;
        for (int s = 0; s < 8; s++) begin
          if (mk[s] && k < seqLen) begin
            expId = (s == 6) ? (alt[0] ? 4'd8 : 4'd6) : 4'(s);
            check(seqId[k] == expId, (s == 6) ? "R4 pointer swap id" : "R2 order",
                  {28'd0, seqId[k]}, {28'd0, expId});
            check(seqVal[k] == slotVal(s, ccIn), (s == 6) ? "R4 pointer value" : "R2 value",
                  {16'd0, seqVal[k]}, {16'd0, slotVal(s, ccIn)});
            k++;
          end
        end
      end
    end

    // R6 and R9: full save with wrap, caller mask and direction ignored
    setRegs(8'hA7);
    ccIn = 8'h15;
    runOp(1'b1, 1'b0, 2'd1, 8'h00, 16'h0002);
    check(finalPtr == 16'hFFF6, "R9 wrap pointer", finalPtr, 16'hFFF6);
    check(cntOut == 4'd12, "R6 full count", {28'd0, cntOut}, 12);
    check(memArr[8'hF6] == 8'h95, "R6 entry flag set", {24'd0, memArr[8'hF6]}, 32'h95);
    checkImage(8'hFF, 16'h0002, 8'h95, "R6 full image");

    // R7: fast save
    setRegs(8'h3C);
    ccIn = 8'hC5;
    runOp(1'b0, 1'b1, 2'd2, 8'h3C, 16'h0240);
    check(cntOut == 4'd3, "R7 fast count", {28'd0, cntOut}, 3);
    check(finalPtr == 16'h023D && finalId == 4'd6, "R7 fast pointer", finalPtr, 16'h023D);
    check(memArr[8'h3D] == 8'h45, "R7 entry flag clear", {24'd0, memArr[8'h3D]}, 32'h45);
    checkImage(8'h81, 16'h0240, 8'h45, "R7 fast image");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule